// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a shared two-port memory array and watches the chip select and address of both ports. When both ports are selected and point at the same location, it picks one port as the owner and flags the other with an active-low busy. The flagged port's write strobe is withheld from the array until the collision ends. The owner is the port that reached its current address and select earlier. A select that arrives last loses, and so does an address that comes to match last. If both arrive in the same cycle, a tie-break input picks the owner.

A mode input lets several devices be cascaded. In master mode the block computes busy itself and drives it out. In slave mode the busy outputs stay released, and each port's write gating follows an externally supplied active-low busy input instead. Everything is sampled on one clock. Outputs are combinational on the current inputs, together with a history captured at earlier rising edges. A one-cycle collision-event pulse marks each new collision.

Top module: `dp_collision_arbiter`

## Requirements
- R1: A collision exists only while both chip selects are high and both addresses are equal. In master mode, with no collision, both busy outputs are 1.
- R2: At the start of a collision, if one port already held its current address with its select high in the previous cycle and the other did not, the first port wins. The loser's busy output reads 0 (busy is active low: 0 means busy).
- R3: If neither port held its current address and select in the previous cycle, the collision started for both in the same cycle. The tie_pick_b input then decides: 0 makes port A win, 1 makes port B win. Exactly one busy is low.
- R4: While a collision continues from one cycle to the next, the winner does not change, whatever happens to write enables or tie_pick_b.
- R5: An address mismatch, or either select going low, releases busy in that same cycle.
- R6: In master mode, the gated write of the losing port is 0. Every other gated write equals that port's write enable ANDed with its chip select.
- R7: In slave mode, both busy outputs are 1. Each gated write is the port's write enable ANDed with its select and its busy input, so a busy input of 0 blocks the write.
- R8: clash_evt is 1 for exactly the first cycle of each collision, in either mode, and never two cycles running.
- R9: Reset holds both busy outputs at 1 and clears all history. The first collision after reset is therefore decided by tie_pick_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 = busy taken from inputs, 0 = busy computed internally |
| tie_pick_b | input | 1 | Winner on simultaneous arrival: 0 = A, 1 = B |
| a_cs | input | 1 | Port A chip select, active high |
| a_addr | input | AW | Port A address |
| a_we | input | 1 | Port A write enable, active high |
| a_busy_in_n | input | 1 | Port A external busy, active low (slave mode) |
| b_cs | input | 1 | Port B chip select, active high |
| b_addr | input | AW | Port B address |
| b_we | input | 1 | Port B write enable, active high |
| b_busy_in_n | input | 1 | Port B external busy, active low (slave mode) |
| a_busy_n | output | 1 | Port A busy, active low |
| a_we_gated | output | 1 | Port A write strobe toward the array |
| b_busy_n | output | 1 | Port B busy, active low |
| b_we_gated | output | 1 | Port B write strobe toward the array |
| clash_evt | output | 1 | One-cycle pulse at the start of a collision |

## Verification
The hardest case to reach is a collision that begins from a particular history. The bench must decide whether one port was already parked on the address or both moved onto it in the same cycle. It must also cover a collision reached by an address change rather than by a select. The bench reaches all of these by sweeping every ordered pair of consecutive port states, each port's select and two-bit address, in both modes and with both tie settings. Each state's history is inherited from the previous pair, so the sequences chain naturally. A directed run then holds one collision for several cycles while toggling write enables and the tie input, to show the winner stays put.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic {SIDE_A = 1'b0, SIDE_B = 1'b1} side_e;

  // A port is "aged" when it was selected at the very same address last cycle.
  function automatic logic port_aged(input logic cs_now, input logic cs_prev,
                                     input logic same_addr);
    return cs_now & cs_prev & same_addr;
  endfunction

  // Older port wins; equal age falls back to the tie-break input.
  function automatic side_e pick_side(input logic a_old, input logic b_old,
                                      input logic tie_b);
    if (a_old && !b_old) return SIDE_A;
    if (b_old && !a_old) return SIDE_B;
    return tie_b ? SIDE_B : SIDE_A;
  endfunction

endpackage

// File: rtl/dpa_port_hist.sv
module dpa_port_hist #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  output logic          aged
);
  logic          cs_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      cs_q   <= cs;
      addr_q <= addr;
    end
  end

  assign aged = dpa_pkg::port_aged(cs, cs_q, addr_q == addr);
endmodule

// File: rtl/dpa_decider.sv
module dpa_decider #(
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           a_cs,
  input  logic           b_cs,
  input  logic [AW-1:0]  a_addr,
  input  logic [AW-1:0]  b_addr,
  input  logic           a_aged,
  input  logic           b_aged,
  input  logic           tie_b,
  output logic           hit,
  output logic           onset,
  output dpa_pkg::side_e winner
);
  import dpa_pkg::*;

  logic  hit_q;
  side_e win_q;

  assign hit    = a_cs & b_cs & (a_addr == b_addr);
  assign onset  = hit & ~hit_q;
  assign winner = onset ? pick_side(a_aged, b_aged, tie_b) : win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      win_q <= SIDE_A;
    end else begin
      hit_q <= hit;
      win_q <= winner;
    end
  end

  AST_EVT_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
    onset |=> !onset); // R8
  AST_ONSET_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    onset |-> (a_cs && b_cs)); // R1
endmodule

// File: rtl/dpa_gate.sv
module dpa_gate (
  input  logic slave_mode,
  input  logic lose,
  input  logic busy_in_n,
  input  logic cs,
  input  logic we,
  output logic busy_n,
  output logic we_gated
);
  logic eff_busy_n;

  assign eff_busy_n = slave_mode ? busy_in_n : ~lose;
  assign busy_n     = slave_mode ? 1'b1 : ~lose;
  assign we_gated   = we & cs & eff_busy_n;
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          tie_pick_b,
  input  logic          a_cs,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic          a_busy_in_n,
  input  logic          b_cs,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic          b_busy_in_n,
  output logic          a_busy_n,
  output logic          a_we_gated,
  output logic          b_busy_n,
  output logic          b_we_gated,
  output logic          clash_evt
);
  import dpa_pkg::*;

  localparam int NP = 2;

  logic [NP-1:0] cs_v, we_v, bin_v, aged_v, lose_v, bsy_v, wg_v;
  logic [AW-1:0] addr_v [NP];
  logic          coll_w, onset_w;
  side_e         winner_w;

  assign cs_v      = {b_cs, a_cs};
  assign we_v      = {b_we, a_we};
  assign bin_v     = {b_busy_in_n, a_busy_in_n};
  assign addr_v[0] = a_addr;
  assign addr_v[1] = b_addr;

  assign lose_v[0] = coll_w & (winner_w == SIDE_B);
  assign lose_v[1] = coll_w & (winner_w == SIDE_A);

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpa_port_hist #(.AW(AW)) u_hist (
      .clk(clk), .rst_n(rst_n), .cs(cs_v[p]), .addr(addr_v[p]), .aged(aged_v[p])
    );
    dpa_gate u_gate (
      .slave_mode(slave_mode), .lose(lose_v[p]), .busy_in_n(bin_v[p]),
      .cs(cs_v[p]), .we(we_v[p]), .busy_n(bsy_v[p]), .we_gated(wg_v[p])
    );
  end

  dpa_decider #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .a_cs(a_cs), .b_cs(b_cs),
    .a_addr(a_addr), .b_addr(b_addr), .a_aged(aged_v[0]), .b_aged(aged_v[1]),
    .tie_b(tie_pick_b), .hit(coll_w), .onset(onset_w), .winner(winner_w)
  );

  assign a_busy_n   = bsy_v[0];
  assign b_busy_n   = bsy_v[1];
  assign a_we_gated = wg_v[0];
  assign b_we_gated = wg_v[1];
  assign clash_evt  = onset_w;

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_busy_n == 1'b0 && b_busy_n == 1'b0)); // R3
  AST_FREE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !(a_cs && b_cs && a_addr == b_addr)) |-> (a_busy_n && b_busy_n)); // R1
  AST_CLASH_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && a_cs && b_cs && a_addr == b_addr) |-> (a_busy_n != b_busy_n)); // R3
  AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && $past(!slave_mode) && coll_w && $past(coll_w))
      |-> (a_busy_n == $past(a_busy_n))); // R4
  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !a_busy_n) |-> !a_we_gated); // R6
  AST_SLAVE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && !b_busy_in_n) |-> !b_we_gated); // R7
  AST_SLAVE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (a_busy_n && b_busy_n)); // R7
endmodule

// File: tb/dp_collision_arbiter_tb.sv
module dp_collision_arbiter_tb;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0, tie_pick_b = 1'b0;
  logic a_cs = 1'b0, b_cs = 1'b0, a_we = 1'b0, b_we = 1'b0;
  logic a_busy_in_n = 1'b1, b_busy_in_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_busy_n, b_busy_n, a_we_gated, b_we_gated, clash_evt;

  int n_chk = 0, n_bad = 0;
  // reference history
  int age_a = 0, age_b = 0;
  logic [AW-1:0] ha = '0, hb = '0;
  bit prev_hit = 0;
  bit win_b = 0;

  always #4 clk = ~clk;

  dp_collision_arbiter #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .tie_pick_b(tie_pick_b),
    .a_cs(a_cs), .a_addr(a_addr), .a_we(a_we), .a_busy_in_n(a_busy_in_n),
    .b_cs(b_cs), .b_addr(b_addr), .b_we(b_we), .b_busy_in_n(b_busy_in_n),
    .a_busy_n(a_busy_n), .a_we_gated(a_we_gated), .b_busy_n(b_busy_n),
    .b_we_gated(b_we_gated), .clash_evt(clash_evt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Apply inputs at the falling edge, compare, then advance the model at the rising edge.
  task automatic step(input bit acs, input logic [AW-1:0] aad, input bit awe, input bit abi,
                      input bit bcs, input logic [AW-1:0] bad, input bit bwe, input bit bbi);
    bit hit, onset, wb, la, lb, ea, eb;
    int ga, gb;
    string tag;
    @(negedge clk);
    a_cs = acs; a_addr = aad; a_we = awe; a_busy_in_n = abi;
    b_cs = bcs; b_addr = bad; b_we = bwe; b_busy_in_n = bbi;
    #1;
    hit   = acs && bcs && (aad == bad);
    onset = hit && !prev_hit;
    ga = (acs && aad == ha) ? age_a : 0;
    gb = (bcs && bad == hb) ? age_b : 0;
    if (onset) wb = (gb > ga) ? 1'b1 : (ga > gb) ? 1'b0 : tie_pick_b;
    else       wb = win_b;
    la = hit && wb;
    lb = hit && !wb;
    if (!hit)            tag = prev_hit ? "R5" : "R1";
    else if (!onset)     tag = "R4";
    else if (ga == gb)   tag = "R3";
    else                 tag = "R2";
    if (slave_mode) begin
      chk(a_busy_n === 1'b1, "R7", "a_busy_n", a_busy_n, 1);
      chk(b_busy_n === 1'b1, "R7", "b_busy_n", b_busy_n, 1);
      ea = abi; eb = bbi;
    end else begin
      chk(a_busy_n === !la, tag, "a_busy_n", a_busy_n, !la);
      chk(b_busy_n === !lb, tag, "b_busy_n", b_busy_n, !lb);
      ea = !la; eb = !lb;
    end
    chk(a_we_gated === (awe && acs && ea), slave_mode ? "R7" : "R6", "a_we_gated",
        a_we_gated, awe && acs && ea);
    chk(b_we_gated === (bwe && bcs && eb), slave_mode ? "R7" : "R6", "b_we_gated",
        b_we_gated, bwe && bcs && eb);
    chk(clash_evt === onset, "R8", "clash_evt", clash_evt, onset);
    @(posedge clk);
    age_a = acs ? ((aad == ha && age_a > 0) ? age_a + 1 : 1) : 0;
    age_b = bcs ? ((bad == hb && age_b > 0) ? age_b + 1 : 1) : 0;
    ha = aad; hb = bad;
    prev_hit = hit;
    win_b = wb;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R9: outputs released while in reset
    repeat (3) @(negedge clk);
    #1;
    chk(a_busy_n === 1'b1, "R9", "a_busy_n in reset", a_busy_n, 1);
    chk(b_busy_n === 1'b1, "R9", "b_busy_n in reset", b_busy_n, 1);
    chk(clash_evt === 1'b0, "R9", "clash_evt in reset", clash_evt, 0);
    @(posedge clk);
    rst_n = 1'b1;
    // R9: first collision after reset is a tie -> tie_pick_b=1 makes B win
    tie_pick_b = 1'b1;
    step(1, 2'd1, 1, 1, 1, 2'd1, 1, 1);
    chk(a_busy_n === 1'b0 && b_busy_n === 1'b1, "R9", "post-reset tie, a_busy_n",
        a_busy_n, 0);
    step(0, 2'd0, 0, 1, 0, 2'd0, 0, 1);

    // R4: held collision with A owning, tie flipped and writes toggled
    tie_pick_b = 1'b0;
    step(1, 2'd3, 0, 1, 0, 2'd0, 0, 1);
    step(1, 2'd3, 1, 1, 1, 2'd3, 1, 1);   // B arrives last, A wins (R2)
    for (int k = 0; k < 6; k++) begin
      tie_pick_b = k[0];
      step(1, 2'd3, k[1], 1, 1, 2'd3, !k[1], 1);
      chk(b_busy_n === 1'b0, "R4", "b keeps losing", b_busy_n, 0);
    end
    step(1, 2'd3, 1, 1, 1, 2'd2, 1, 1);   // R5 mismatch release
    chk(a_busy_n === 1'b1 && b_busy_n === 1'b1, "R5", "release both", b_busy_n, 1);
    step(1, 2'd2, 1, 1, 1, 2'd2, 1, 1);   // address comes to match: B was parked at 2 -> B wins
    chk(a_busy_n === 1'b0, "R2", "address-move loser A", a_busy_n, 0);

    // near-exhaustive sweep over consecutive state pairs
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 2; t++) begin
        slave_mode = m[0];
        tie_pick_b = t[0];
        for (int s0 = 0; s0 < 64; s0++) begin
          for (int s1 = 0; s1 < 64; s1++) begin
            logic [5:0] p, q;
            p = s0[5:0]; q = s1[5:0];
            step(p[5], p[4:3], p[0] ^ q[1], q[2] ^ p[3], p[2], p[1:0], q[0], p[4] ^ q[5]);
            step(q[5], q[4:3], q[3] ^ p[2], p[1], q[2], q[1:0], p[5] ^ q[4], q[0] ^ p[0]);
          end
        end
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule